// File: doc/BRIEF.md
# Prioritised Trigger Channel Arbiter

This block watches sixteen internal trigger channels. Software decides, for each channel, whether it may take part and whether it reacts to a rising edge or to a high level. On any clock cycle where at least one qualified channel fires, the block raises a single trigger request. The request carries a 4-bit trigger type. The type is looked up in a software-programmed table, at the entry of the lowest-numbered channel that fired. Channel 0 therefore beats every other channel.

A busy input from the downstream event logic holds back new requests. Channel activity that occurs while busy is high still reaches the per-channel statistics, but it raises no request.

Each channel has two wrapping counters: one counts sampled-high cycles and the other counts low-to-high transitions. Configuration, the type table and the counters are all reached through a flat word-addressed register port. Writes to this port take effect at the clock edge. Reads are combinational.

Top module: `trig_chan_arbiter`

## Requirements
- R1: After reset every channel is disabled, the control word and both type words read 0, all counters read 0, and trig_req_o and trig_type_o are 0.
- R2: The control word sits at address 0. Bit i (0..15) enables channel i, and bit 16+i selects edge sensitivity (1) or level sensitivity (0) for channel i. A disabled channel never causes a request, whatever its input does.
- R3: A level-sensitive enabled channel fires on every sampled cycle in which its input is high.
- R4: An edge-sensitive enabled channel fires only on the first sampled high cycle that follows a sampled low cycle.
- R5: When several channels fire in the same cycle, the reported type is the one belonging to the lowest-numbered firing channel. If that channel is edge-sensitive, a level-sensitive loser takes over on the next cycle.
- R6: The type table sits at addresses 1 and 2. Channel i's type is in the word at address 1+i/8, bits 4*(i%8)+3 down to 4*(i%8), so channel 0 is the low nibble of address 1. Both words read back as written.
- R7: trig_req_o is asserted exactly two rising clock edges after a firing input value is applied (one sampling register, one output register). trig_type_o is valid while trig_req_o is high and is 0 otherwise.
- R8: If busy_i is high at the clock edge that would register a request, no request is produced for that cycle. An edge event swallowed this way is not replayed later.
- R9: The counter at address 32+2i counts the clock cycles in which channel i was sampled high, whether or not the channel is enabled and whether or not busy_i is high. It wraps silently.
- R10: The counter at address 33+2i counts the sampled low-to-high transitions of channel i, under the same conditions. Every edge count step coincides with a level count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_i | input | 16 | Trigger channel inputs, bit i = channel i |
| busy_i | input | 1 | Downstream busy; suppresses new requests |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| trig_req_o | output | 1 | Registered trigger request |
| trig_type_o | output | 4 | Type of the winning channel, 0 when idle |

## Verification
Two situations are exercised in which separate functions meet in the same cycle.

In the first, a channel fires while busy_i is high. Both a held level channel and a single edge are driven under busy. The bench checks that the level channel's request appears on the first edge after busy drops, and that the edge event never appears at all.

In the second, an edge-sensitive channel and a level-sensitive channel rise together. The bench checks that the first request carries the edge channel's type and that the very next one carries the level channel's type. The priority judgement is made against a table of mixed multi-bit patterns and against every single-bit pattern.

// File: rtl/trig_arb_pkg.sv
package trig_arb_pkg;
  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_TYPE0    = 1;
  localparam int ADDR_CNT_BASE = 32;
endpackage

// File: rtl/trig_qualify.sv
module trig_qualify #(
  parameter int N_CH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] chan_i,
  input  logic [N_CH-1:0] en_i,
  input  logic [N_CH-1:0] edge_sel_i,
  output logic [N_CH-1:0] samp_o,
  output logic [N_CH-1:0] rise_o,
  output logic [N_CH-1:0] fire_o
);
  logic [N_CH-1:0] chan_q, chan_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q      <= '0;
      chan_prev_q <= '0;
    end else begin
      chan_q      <= chan_i;
      chan_prev_q <= chan_q;
    end
  end

  assign samp_o = chan_q;
  assign rise_o = chan_q & ~chan_prev_q;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign fire_o[i] = en_i[i] & (edge_sel_i[i] ? rise_o[i] : chan_q[i]);

    // edge mode never fires two cycles running
    a_r4_edge_once : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_o[i] && edge_sel_i[i]) |=> !(fire_o[i] && edge_sel_i[i]));
  end
endmodule

// File: rtl/trig_stat_cnt.sv
module trig_stat_cnt #(
  parameter int N_CH  = 16,
  parameter int CNT_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CH-1:0]            samp_i,
  input  logic [N_CH-1:0]            rise_i,
  output logic [N_CH-1:0][CNT_W-1:0] lvl_cnt_o,
  output logic [N_CH-1:0][CNT_W-1:0] edg_cnt_o
);
  for (genvar i = 0; i < N_CH; i++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_cnt_o[i] <= '0;
        edg_cnt_o[i] <= '0;
      end else begin
        if (samp_i[i]) lvl_cnt_o[i] <= lvl_cnt_o[i] + 1'b1;
        if (rise_i[i]) edg_cnt_o[i] <= edg_cnt_o[i] + 1'b1;
      end
    end

    a_r10_edge_with_level : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edg_cnt_o[i] != $past(edg_cnt_o[i])) |-> (lvl_cnt_o[i] != $past(lvl_cnt_o[i])));
  end
endmodule

// File: rtl/trig_prio_enc.sv
module trig_prio_enc #(
  parameter int N_CH   = 16,
  parameter int TYPE_W = 4
) (
  input  logic [N_CH-1:0]        fire_i,
  input  logic [N_CH*TYPE_W-1:0] type_flat_i,
  output logic                   hit_o,
  output logic [TYPE_W-1:0]      type_o
);
  localparam int IDX_W = $clog2(N_CH);

  logic [IDX_W-1:0] win;

  always_comb begin
    win = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (fire_i[i]) win = IDX_W'(i);
    end
    hit_o  = |fire_i;
    type_o = type_flat_i[win*TYPE_W +: TYPE_W];
  end
endmodule

// File: rtl/trig_chan_arbiter.sv
module trig_chan_arbiter
  import trig_arb_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int TYPE_W = 4,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   chan_i,
  input  logic              busy_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              trig_req_o,
  output logic [TYPE_W-1:0] trig_type_o
);
  localparam int CTRL_W   = 2 * N_CH;
  localparam int TBL_W    = N_CH * TYPE_W;
  localparam int N_TWORDS = TBL_W / DATA_W;

  logic [CTRL_W-1:0]             ctrl_q;
  logic [TBL_W-1:0]              type_q;
  logic [N_CH-1:0]               en, edge_sel, samp, rise, fire;
  logic [N_CH-1:0][CNT_W-1:0]    lvl_cnt, edg_cnt;
  logic                          hit;
  logic [TYPE_W-1:0]             win_type;

  assign en       = ctrl_q[N_CH-1:0];
  assign edge_sel = ctrl_q[CTRL_W-1:N_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      type_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_W'(ADDR_CTRL)) ctrl_q <= reg_wdata_i[CTRL_W-1:0];
      for (int w = 0; w < N_TWORDS; w++) begin
        if (reg_addr_i == ADDR_W'(ADDR_TYPE0 + w)) type_q[w*DATA_W +: DATA_W] <= reg_wdata_i;
      end
    end
  end

  trig_qualify #(.N_CH(N_CH)) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chan_i     (chan_i),
    .en_i       (en),
    .edge_sel_i (edge_sel),
    .samp_o     (samp),
    .rise_o     (rise),
    .fire_o     (fire)
  );

  trig_stat_cnt #(.N_CH(N_CH), .CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .samp_i    (samp),
    .rise_i    (rise),
    .lvl_cnt_o (lvl_cnt),
    .edg_cnt_o (edg_cnt)
  );

  trig_prio_enc #(.N_CH(N_CH), .TYPE_W(TYPE_W)) u_prio (
    .fire_i      (fire),
    .type_flat_i (type_q),
    .hit_o       (hit),
    .type_o      (win_type)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_req_o  <= 1'b0;
      trig_type_o <= '0;
    end else begin
      trig_req_o  <= hit & ~busy_i;
      trig_type_o <= (hit & ~busy_i) ? win_type : '0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(ADDR_CTRL)) reg_rdata_o = DATA_W'(ctrl_q);
    for (int w = 0; w < N_TWORDS; w++) begin
      if (reg_addr_i == ADDR_W'(ADDR_TYPE0 + w)) reg_rdata_o = type_q[w*DATA_W +: DATA_W];
    end
    for (int c = 0; c < N_CH; c++) begin
      if (reg_addr_i == ADDR_W'(ADDR_CNT_BASE + 2*c))     reg_rdata_o = DATA_W'(lvl_cnt[c]);
      if (reg_addr_i == ADDR_W'(ADDR_CNT_BASE + 2*c + 1)) reg_rdata_o = DATA_W'(edg_cnt[c]);
    end
  end

  a_r2_no_enable_no_req : assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_req_o |-> ($past(en) != '0));

  a_r8_busy_blocks : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> !trig_req_o);

  a_r7_idle_type_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trig_req_o) |-> (trig_type_o == '0));
endmodule

// File: tb/trig_chan_arbiter_test.sv
module trig_chan_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] chan = '0;
  logic        busy = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req;
  logic [3:0]  ttype;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trig_chan_arbiter uut (
    .clk_i(clk), .rst_ni(rst_ni), .chan_i(chan), .busy_i(busy),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .trig_req_o(req), .trig_type_o(ttype)
  );

  // {pattern, expected winner}
  localparam logic [19:0] VECS [0:7] = '{
    20'h0001_0, 20'h8000_F, 20'h0100_8, 20'h0180_7,
    20'hFFFF_0, 20'hA000_D, 20'h0006_1, 20'h4010_4
  };

  function automatic logic [3:0] exp_type(input int ch);
    return 4'((ch * 7 + 3) & 15);
  endfunction

  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] v = '0;
    for (int j = 0; j < 8; j++) v[4*j +: 4] = exp_type(8*w + j);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // hold channel ch high for 4 cycles, count request cycles
  task automatic pulse_count(input int ch, output int cnt);
    cnt = 0;
    @(negedge clk);
    chan = 16'(1 << ch);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (req) cnt++;
      if (k == 3) chan = '0;
    end
  endtask

  task automatic idle(input int n);
    chan = '0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, l0, e0, l1, e1;
    int cnt;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 req", 32'(req), 0);
    chk("R1 type", 32'(ttype), 0);
    rd(6'd0, d);  chk("R1 ctrl", d, 0);
    rd(6'd1, d);  chk("R1 type word0", d, 0);
    rd(6'd2, d);  chk("R1 type word1", d, 0);
    rd(6'd32, d); chk("R1 level count ch0", d, 0);

    // R2 disabled channels never request
    @(negedge clk);
    chan = 16'hFFFF;
    cnt = 0;
    repeat (5) begin @(negedge clk); if (req) cnt++; end
    chk("R2 disabled no request", 32'(cnt), 0);
    idle(3);

    // R6 type table
    wr(6'd1, exp_word(0));
    wr(6'd2, exp_word(1));
    rd(6'd1, d); chk("R6 type word0", d, exp_word(0));
    rd(6'd2, d); chk("R6 type word1", d, exp_word(1));

    // R7 latency, all channels level mode
    wr(6'd0, 32'h0000_FFFF);
    chan = 16'h0001;
    @(negedge clk);
    chk("R7 no request after one edge", 32'(req), 0);
    @(negedge clk);
    chk("R7 request after two edges", 32'(req), 1);
    chk("R7 type ch0", 32'(ttype), 32'(exp_type(0)));
    idle(3);
    chk("R7 idle type zero", 32'(ttype), 0);

    // R5 priority table
    foreach (VECS[v]) begin
      chan = VECS[v][19:4];
      repeat (2) @(negedge clk);
      chk($sformatf("R5 vec%0d req", v), 32'(req), 1);
      chk($sformatf("R5 vec%0d type", v), 32'(ttype), 32'(exp_type(int'(VECS[v][3:0]))));
      idle(3);
    end

    // R5 every single-bit pattern
    for (int i = 0; i < 16; i++) begin
      chan = 16'(1 << i);
      repeat (2) @(negedge clk);
      chk($sformatf("R5 single ch%0d", i), 32'(ttype), 32'(exp_type(i)));
      idle(3);
    end

    // R3 level: four high cycles give four requests
    pulse_count(9, cnt);
    chk("R3 level request cycles", 32'(cnt), 4);

    // R4 edge: one request
    wr(6'd0, 32'hFFFF_FFFF);
    pulse_count(9, cnt);
    chk("R4 edge request cycles", 32'(cnt), 1);

    // R5 mixed: ch1 edge, ch4 level, rising together
    wr(6'd0, 32'h0002_0012);
    idle(2);
    chan = 16'h0012;
    repeat (2) @(negedge clk);
    chk("R5 mixed first type ch1", 32'(ttype), 32'(exp_type(1)));
    @(negedge clk);
    chk("R5 mixed next type ch4", 32'(ttype), 32'(exp_type(4)));
    idle(3);

    // R8 busy with level channel
    wr(6'd0, 32'h0000_0020);
    busy = 1'b1;
    chan = 16'h0020;
    repeat (3) @(negedge clk);
    chk("R8 busy holds level", 32'(req), 0);
    busy = 1'b0;
    @(negedge clk);
    chk("R8 released request", 32'(req), 1);
    chk("R8 released type", 32'(ttype), 32'(exp_type(5)));
    idle(3);

    // R8 busy swallows an edge
    wr(6'd0, 32'h0020_0020);
    busy = 1'b1;
    chan = 16'h0020;
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (req) cnt++;
      if (k == 3) busy = 1'b0;
    end
    chk("R8 edge lost under busy", 32'(cnt), 0);
    idle(3);

    // R9 R10 counters, channel disabled
    wr(6'd0, 32'h0);
    rd(6'd38, l0); rd(6'd39, e0);
    chan = 16'h0008;
    repeat (5) @(negedge clk);
    chan = '0;
    repeat (2) @(negedge clk);
    chan = 16'h0008;
    repeat (2) @(negedge clk);
    idle(3);
    rd(6'd38, l1); rd(6'd39, e1);
    chk("R9 level count delta ch3", l1 - l0, 7);
    chk("R10 edge count delta ch3", e1 - e0, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule